// File: doc/BRIEF.md
# Receive Buffer Element Allocator

This block sits behind a 32-bit receive media bus and turns the incoming word stream into filled buffer elements for a pool of worker threads. It keeps two FIFO free lists. One holds the numbers of free buffer elements. The other holds the IDs of threads that have registered as waiting for work. Words marked idle are thrown away before they can claim an element.

Each accepted word is written into the element currently being filled. When an element closes, a status word describing it is queued. An element closes when it is full or when the frame ends. As soon as a waiting thread exists, the oldest queued status is pushed to the oldest waiting thread, without that thread asking for it. Frames larger than one element continue in further elements. A thread hands its element number back through the release port once it has moved the data out.

The pool shape is chosen by a parameter: 64 elements of 128 bytes (the default) or 128 elements of 64 bytes.

Top module: `rx_elem_alloc`

## Requirements
- R1: With the default parameters the pool holds 64 elements of 128 bytes (32 words). After reset the element free list hands out indices in ascending order starting at 0, and every element index written is below 64.
- R2: A word presented with `rx_idle` high is ignored whether or not it carries start or end marks. It causes no write, takes no element and does not count toward the byte total.
- R3: The first word of a frame takes the element at the head of the element free list. Each accepted word is written one cycle later to `wr_elem`, at word index `wr_word`, counting from 0 within that element in arrival order.
- R4: The status word is laid out with the element index in bits 17:11, the byte count in bits 10:3, the start flag in bit 2, the end flag in bit 1 and the error flag in bit 0.
- R5: The byte count adds 4 for every word except the end word. The end word adds `rx_nbytes`, where the encoding 0 means 4 and 1 to 3 mean that many bytes.
- R6: Each status goes to the thread at the head of the thread free list. Threads are served in registration order, one status per registration.
- R7: A status with no waiting thread is held. Held statuses are delivered in the order their elements closed once threads register. No status is pushed while the thread list is empty.
- R8: A frame longer than one element continues in the next free element, and every element gets its own status. Only the first element of the frame has the start flag set and only the last has the end flag set. Every non-final element reports a full byte count.
- R9: If the element free list is empty when a frame starts, the whole frame is discarded and `drop_count` increases by one.
- R10: If the element free list is empty when a frame needs a further element, the rest of the frame is discarded and `drop_count` increases by one. Statuses of the elements already closed are still delivered.
- R11: A released element number joins the tail of the element free list and is handed out again only after every element ahead of it.
- R12: `rx_err` sampled on the end word sets the error flag in that frame's last status.
- R13: During and right after reset, `wr_valid` and `st_valid` are low, `drop_count` is 0 and the thread free list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A receive word is present |
| rx_data | input | 32 | Receive word |
| rx_sop | input | 1 | Word starts a frame |
| rx_eop | input | 1 | Word ends a frame |
| rx_idle | input | 1 | Word is idle fill and must be dropped |
| rx_nbytes | input | 2 | Valid bytes in the end word (0 means 4) |
| rx_err | input | 1 | Frame error, sampled on the end word |
| thr_reg_valid | input | 1 | A thread registers as waiting |
| thr_reg_id | input | THR_W | ID of the registering thread |
| rel_valid | input | 1 | A thread returns an element |
| rel_elem | input | 7 | Element number being returned |
| wr_valid | output | 1 | Element write strobe |
| wr_elem | output | 7 | Element being written |
| wr_word | output | WIDX_W | Word index within the element |
| wr_data | output | 32 | Word being written |
| st_valid | output | 1 | Status push strobe |
| st_thread | output | THR_W | Thread receiving the status |
| st_word | output | 18 | Status word (layout in R4) |
| drop_count | output | DROP_W | Count of discarded frames and frame tails |

## Verification
The assertions rely on a few rules about the inputs. A thread never registers while its ID is already waiting. An element is released only after its status has been delivered and only while it is held, so neither free list nor the status queue can be pushed past its depth. Frames are well formed: no new start mark arrives before the previous end mark, and `rx_err` and `rx_nbytes` matter only on end words. The stimulus follows these rules in three ways. It keeps a model of held elements and releases them only after draining every pending status. It registers thread IDs in a rotating sequence, never holding more than sixteen waiting at once. It builds every frame from a single task that places the marks itself.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int ELEM_IDX_W = 7;
    localparam int BYTE_CNT_W = 8;

    typedef struct packed {
        logic [ELEM_IDX_W-1:0] elem;
        logic [BYTE_CNT_W-1:0] bytes;
        logic                  sop;
        logic                  eop;
        logic                  err;
    } rx_status_t;

    localparam int STATUS_W = $bits(rx_status_t);

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FILL,
        FS_SPILL,
        FS_DISCARD
    } fill_state_e;

    function automatic int pool_elems(bit small_elems);
        return small_elems ? 128 : 64;
    endfunction

    function automatic int pool_elem_bytes(bit small_elems);
        return small_elems ? 64 : 128;
    endfunction

    function automatic logic [2:0] word_bytes(logic eop, logic [1:0] nbytes);
        if (!eop)
            return 3'd4;
        return (nbytes == 2'd0) ? 3'd4 : {1'b0, nbytes};
    endfunction

endpackage

// File: rtl/rxb_id_fifo.sv
module rxb_id_fifo #(
    parameter int W       = 7,
    parameter int DEPTH   = 64,
    parameter bit PRELOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (PRELOAD) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= W'(i);
            end
        end else if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= PRELOAD ? CW'(DEPTH) : '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && count == CW'(DEPTH)) |-> pop); // R11

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0)); // R9

endmodule

// File: rtl/rxb_fill_ctrl.sv
module rxb_fill_ctrl
    import rxb_pkg::*;
#(
    parameter int ELEM_BYTES = 128,
    parameter int WIDX_W     = 5,
    parameter int DROP_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic [31:0]           rx_data,
    input  logic                  rx_sop,
    input  logic                  rx_eop,
    input  logic                  rx_idle,
    input  logic [1:0]            rx_nbytes,
    input  logic                  rx_err,
    input  logic [ELEM_IDX_W-1:0] free_head,
    input  logic                  free_empty,
    output logic                  free_pop,
    output logic                  wr_valid,
    output logic [ELEM_IDX_W-1:0] wr_elem,
    output logic [WIDX_W-1:0]     wr_word,
    output logic [31:0]           wr_data,
    output logic                  st_push,
    output rx_status_t            st_data,
    output logic [DROP_W-1:0]     drop_count
);
    localparam logic [BYTE_CNT_W-1:0] FULL_BYTES = BYTE_CNT_W'(ELEM_BYTES);

    fill_state_e           state_q, state_d;
    logic [ELEM_IDX_W-1:0] elem_q, elem_d;
    logic [BYTE_CNT_W-1:0] bytes_q, bytes_d;
    logic                  esop_q, esop_d;
    logic [DROP_W-1:0]     drop_q, drop_d;

    logic                  accept;
    logic                  take_new;
    logic                  go;
    logic [ELEM_IDX_W-1:0] use_elem;
    logic [BYTE_CNT_W-1:0] base;
    logic [BYTE_CNT_W-1:0] new_bytes;
    logic                  use_sop;
    logic                  wr_en;
    logic [WIDX_W-1:0]     wr_idx_d;

    assign accept   = rx_valid && !rx_idle;
    assign take_new = rx_sop || (state_q == FS_SPILL);

    always_comb begin
        state_d   = state_q;
        elem_d    = elem_q;
        bytes_d   = bytes_q;
        esop_d    = esop_q;
        drop_d    = drop_q;
        free_pop  = 1'b0;
        go        = 1'b0;
        use_elem  = elem_q;
        base      = bytes_q;
        use_sop   = esop_q;
        new_bytes = bytes_q;
        wr_en     = 1'b0;
        wr_idx_d  = '0;
        st_push   = 1'b0;
        st_data   = '0;

        if (accept) begin
            if (take_new) begin
                if (!free_empty) begin
                    free_pop = 1'b1;
                    go       = 1'b1;
                    use_elem = free_head;
                    base     = '0;
                    use_sop  = rx_sop;
                end else begin
                    drop_d  = drop_q + 1'b1;
                    state_d = rx_eop ? FS_IDLE : FS_DISCARD;
                end
            end else if (state_q == FS_FILL) begin
                go = 1'b1;
            end else if (state_q == FS_DISCARD && rx_eop) begin
                state_d = FS_IDLE;
            end

            if (go) begin
                wr_en     = 1'b1;
                wr_idx_d  = WIDX_W'(base >> 2);
                new_bytes = base + BYTE_CNT_W'(word_bytes(rx_eop, rx_nbytes));
                elem_d    = use_elem;
                bytes_d   = new_bytes;
                esop_d    = use_sop;
                if (rx_eop || new_bytes == FULL_BYTES) begin
                    st_push       = 1'b1;
                    st_data.elem  = use_elem;
                    st_data.bytes = new_bytes;
                    st_data.sop   = use_sop;
                    st_data.eop   = rx_eop;
                    st_data.err   = rx_eop && rx_err;
                    state_d       = rx_eop ? FS_IDLE : FS_SPILL;
                end else begin
                    state_d = FS_FILL;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FS_IDLE;
            elem_q   <= '0;
            bytes_q  <= '0;
            esop_q   <= 1'b0;
            drop_q   <= '0;
            wr_valid <= 1'b0;
            wr_elem  <= '0;
            wr_word  <= '0;
            wr_data  <= '0;
        end else begin
            state_q  <= state_d;
            elem_q   <= elem_d;
            bytes_q  <= bytes_d;
            esop_q   <= esop_d;
            drop_q   <= drop_d;
            wr_valid <= wr_en;
            wr_elem  <= use_elem;
            wr_word  <= wr_idx_d;
            wr_data  <= rx_data;
        end
    end

    assign drop_count = drop_q;

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_idle) |=> !wr_valid); // R2

    AST_STATUS_BYTES: assert property (@(posedge clk) disable iff (rst)
        st_push |-> (st_data.bytes != '0 && st_data.bytes <= FULL_BYTES)); // R5

    AST_OPEN_ELEM_FULL: assert property (@(posedge clk) disable iff (rst)
        (st_push && !st_data.eop) |-> (st_data.bytes == FULL_BYTES)); // R8

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1)); // R9

endmodule

// File: rtl/rx_elem_alloc.sv
module rx_elem_alloc
    import rxb_pkg::*;
#(
    parameter bit SMALL_ELEMS = 1'b0,
    parameter int NUM_THREADS = 16,
    parameter int DROP_W      = 16,
    localparam int NUM_ELEMS  = pool_elems(SMALL_ELEMS),
    localparam int ELEM_BYTES = pool_elem_bytes(SMALL_ELEMS),
    localparam int WIDX_W     = $clog2(ELEM_BYTES / 4),
    localparam int THR_W      = $clog2(NUM_THREADS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic [31:0]           rx_data,
    input  logic                  rx_sop,
    input  logic                  rx_eop,
    input  logic                  rx_idle,
    input  logic [1:0]            rx_nbytes,
    input  logic                  rx_err,
    input  logic                  thr_reg_valid,
    input  logic [THR_W-1:0]      thr_reg_id,
    input  logic                  rel_valid,
    input  logic [ELEM_IDX_W-1:0] rel_elem,
    output logic                  wr_valid,
    output logic [ELEM_IDX_W-1:0] wr_elem,
    output logic [WIDX_W-1:0]     wr_word,
    output logic [31:0]           wr_data,
    output logic                  st_valid,
    output logic [THR_W-1:0]      st_thread,
    output logic [STATUS_W-1:0]   st_word,
    output logic [DROP_W-1:0]     drop_count
);
    logic [ELEM_IDX_W-1:0] free_head;
    logic                  free_empty;
    logic                  free_pop;

    logic                  st_push;
    rx_status_t            st_data;
    logic [STATUS_W-1:0]   stq_head;
    logic                  stq_empty;

    logic [THR_W-1:0]      thr_head;
    logic                  thr_empty;
    logic                  deliver;

    rxb_id_fifo #(
        .W       (ELEM_IDX_W),
        .DEPTH   (NUM_ELEMS),
        .PRELOAD (1'b1)
    ) u_elem_free (
        .clk   (clk),
        .rst   (rst),
        .push  (rel_valid),
        .wdata (rel_elem),
        .pop   (free_pop),
        .head  (free_head),
        .empty (free_empty)
    );

    rxb_fill_ctrl #(
        .ELEM_BYTES (ELEM_BYTES),
        .WIDX_W     (WIDX_W),
        .DROP_W     (DROP_W)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sop     (rx_sop),
        .rx_eop     (rx_eop),
        .rx_idle    (rx_idle),
        .rx_nbytes  (rx_nbytes),
        .rx_err     (rx_err),
        .free_head  (free_head),
        .free_empty (free_empty),
        .free_pop   (free_pop),
        .wr_valid   (wr_valid),
        .wr_elem    (wr_elem),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .st_push    (st_push),
        .st_data    (st_data),
        .drop_count (drop_count)
    );

    rxb_id_fifo #(
        .W       (STATUS_W),
        .DEPTH   (NUM_ELEMS),
        .PRELOAD (1'b0)
    ) u_status_q (
        .clk   (clk),
        .rst   (rst),
        .push  (st_push),
        .wdata (st_data),
        .pop   (deliver),
        .head  (stq_head),
        .empty (stq_empty)
    );

    rxb_id_fifo #(
        .W       (THR_W),
        .DEPTH   (NUM_THREADS),
        .PRELOAD (1'b0)
    ) u_thread_free (
        .clk   (clk),
        .rst   (rst),
        .push  (thr_reg_valid),
        .wdata (thr_reg_id),
        .pop   (deliver),
        .head  (thr_head),
        .empty (thr_empty)
    );

    assign deliver = !stq_empty && !thr_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid  <= 1'b0;
            st_thread <= '0;
            st_word   <= '0;
        end else begin
            st_valid  <= deliver;
            st_thread <= thr_head;
            st_word   <= stq_head;
        end
    end

    AST_WR_ELEM_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_elem < ELEM_IDX_W'(NUM_ELEMS))); // R1

    AST_NO_PUSH_WITHOUT_THREAD: assert property (@(posedge clk) disable iff (rst)
        thr_empty |=> !st_valid); // R7

endmodule

// File: tb/rx_elem_alloc_tb.sv
module rx_elem_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE     = 64;
    localparam int EB     = 128;
    localparam int WIDX_W = 5;
    localparam int THR_W  = 4;
    localparam int NTHR   = 16;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [31:0]       rx_data = '0;
    logic              rx_sop = 1'b0;
    logic              rx_eop = 1'b0;
    logic              rx_idle = 1'b0;
    logic [1:0]        rx_nbytes = '0;
    logic              rx_err = 1'b0;
    logic              thr_reg_valid = 1'b0;
    logic [THR_W-1:0]  thr_reg_id = '0;
    logic              rel_valid = 1'b0;
    logic [6:0]        rel_elem = '0;
    logic              wr_valid;
    logic [6:0]        wr_elem;
    logic [WIDX_W-1:0] wr_word;
    logic [31:0]       wr_data;
    logic              st_valid;
    logic [THR_W-1:0]  st_thread;
    logic [17:0]       st_word;
    logic [15:0]       drop_count;

    rx_elem_alloc u_dut (
        .clk           (clk),
        .rst           (rst),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_sop        (rx_sop),
        .rx_eop        (rx_eop),
        .rx_idle       (rx_idle),
        .rx_nbytes     (rx_nbytes),
        .rx_err        (rx_err),
        .thr_reg_valid (thr_reg_valid),
        .thr_reg_id    (thr_reg_id),
        .rel_valid     (rel_valid),
        .rel_elem      (rel_elem),
        .wr_valid      (wr_valid),
        .wr_elem       (wr_elem),
        .wr_word       (wr_word),
        .wr_data       (wr_data),
        .st_valid      (st_valid),
        .st_thread     (st_thread),
        .st_word       (st_word),
        .drop_count    (drop_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int st_seen = 0;

    // scoreboard queues
    logic [43:0] exp_wr[$];
    logic [17:0] exp_st[$];
    string       exp_st_tag[$];
    logic [3:0]  exp_thr[$];
    // bench model of the pool
    int          efree[$];
    int          held[$];
    int          drop_exp = 0;
    int          next_tid = 0;
    int          frame_no = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'(WATCHDOG));
            summary_and_end();
        end
    end

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {20'd0, wr_elem, wr_word, wr_data}, 64'd0);
                end else begin
                    logic [43:0] e;
                    e = exp_wr.pop_front();
                    chk({wr_elem, wr_word, wr_data} == e, "R3 element write",
                        {20'd0, wr_elem, wr_word, wr_data}, {20'd0, e});
                end
            end
            if (st_valid) begin
                st_seen++;
                if (exp_st.size() == 0 || exp_thr.size() == 0) begin
                    chk(1'b0, "R7 unexpected status", {46'd0, st_word}, 64'd0);
                end else begin
                    logic [17:0] s;
                    logic [3:0]  t;
                    string       tg;
                    s  = exp_st.pop_front();
                    tg = exp_st_tag.pop_front();
                    t  = exp_thr.pop_front();
                    chk(st_word == s, tg, {46'd0, st_word}, {46'd0, s});
                    chk(st_thread == t, "R6 thread order", {60'd0, st_thread}, {60'd0, t});
                end
            end
        end
    end

    task automatic clear_inputs();
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_idle = 1'b0;
        rx_nbytes = '0; rx_err = 1'b0; rx_data = '0;
        thr_reg_valid = 1'b0; rel_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_inputs();
        end
    endtask

    task automatic reg_thread();
        @(negedge clk);
        clear_inputs();
        thr_reg_valid = 1'b1;
        thr_reg_id    = THR_W'(next_tid);
        exp_thr.push_back(4'(next_tid));
        next_tid = (next_tid + 1) % NTHR;
    endtask

    task automatic release_elem(input int e);
        @(negedge clk);
        clear_inputs();
        rel_valid = 1'b1;
        rel_elem  = 7'(e);
        efree.push_back(e);
    endtask

    task automatic idle_word(input bit sop, input bit eop);
        @(negedge clk);
        clear_inputs();
        rx_valid = 1'b1; rx_idle = 1'b1; rx_sop = sop; rx_eop = eop;
        rx_data  = 32'hDEAD_0000;
    endtask

    // drive one frame and update the model; idle_at < 0 means no idle word inside
    task automatic send_frame(input int nwords, input int last_nb, input bit err,
                              input int idle_at, input string tag);
        int  st;      // 0 idle, 1 fill, 2 spill, 3 discard
        int  mel;
        int  mb;
        bit  msop;
        st = 0; mel = 0; mb = 0; msop = 0;
        frame_no++;
        for (int w = 0; w < nwords; w++) begin
            bit sop;
            bit eop;
            logic [31:0] d;
            if (w == idle_at)
                idle_word(1'b0, 1'b0);
            sop = (w == 0);
            eop = (w == nwords - 1);
            d   = {8'(frame_no), 8'hA5, 16'(w)};
            @(negedge clk);
            clear_inputs();
            rx_valid = 1'b1; rx_data = d; rx_sop = sop; rx_eop = eop;
            rx_nbytes = eop ? 2'(last_nb) : 2'd0;
            rx_err = eop ? err : 1'b0;
            if (sop || st == 2) begin
                if (efree.size() > 0) begin
                    mel = efree.pop_front(); mb = 0; msop = sop; st = 1;
                end else begin
                    drop_exp++;
                    st = eop ? 0 : 3;
                end
            end else if (st == 3 && eop) begin
                st = 0;
            end
            if (st == 1) begin
                int wb;
                exp_wr.push_back({7'(mel), 5'(mb / 4), d});
                wb = (eop && last_nb != 0) ? last_nb : 4;
                mb += wb;
                if (eop || mb == EB) begin
                    exp_st.push_back({7'(mel), 8'(mb), msop, eop, eop & err});
                    exp_st_tag.push_back(tag);
                    held.push_back(mel);
                    st = eop ? 0 : 2;
                end
            end
        end
        idle(1);
    endtask

    task automatic drain();
        for (int k = 0; k < 4000 && exp_st.size() > 0; k++) begin
            if (exp_thr.size() < exp_st.size() && exp_thr.size() < NTHR)
                reg_thread();
            else
                idle(1);
        end
        idle(4);
        chk(exp_st.size() == 0, "R6 statuses drained", 64'(exp_st.size()), 64'd0);
    endtask

    task automatic release_all();
        while (held.size() > 0)
            release_elem(held.pop_front());
        idle(2);
    endtask

    initial begin
        for (int i = 0; i < NE; i++)
            efree.push_back(i);
        clear_inputs();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R13: reset state
        chk(wr_valid == 1'b0, "R13 wr_valid in reset", 64'(wr_valid), 64'd0);
        chk(st_valid == 1'b0, "R13 st_valid in reset", 64'(st_valid), 64'd0);
        chk(drop_count == 16'd0, "R13 drop_count in reset", 64'(drop_count), 64'd0);
        rst = 1'b0;
        idle(2);
        chk(drop_count == 16'd0, "R13 drop_count after reset", 64'(drop_count), 64'd0);

        // R1 R3 R7: first frame lands in element 0, status held with no thread
        send_frame(3, 0, 1'b0, -1, "R1 R4 first element");
        idle(10);
        chk(st_seen == 0, "R7 status held without thread", 64'(st_seen), 64'd0);
        chk(exp_wr.size() == 0, "R3 writes of first frame", 64'(exp_wr.size()), 64'd0);
        // R7 R13: thread list empty after reset, the first registration releases it
        drain();
        chk(st_seen == 1, "R7 held status delivered", 64'(st_seen), 64'd1);

        // R7: several held statuses keep close order
        send_frame(2, 1, 1'b0, -1, "R7 held order a");
        send_frame(1, 2, 1'b0, -1, "R7 held order b");
        send_frame(4, 3, 1'b0, -1, "R7 held order c");
        drain();

        // R5: each end-word byte code, R12: error flag
        send_frame(5, 1, 1'b0, -1, "R5 one byte tail");
        send_frame(5, 2, 1'b0, -1, "R5 two byte tail");
        send_frame(5, 3, 1'b0, -1, "R5 three byte tail");
        send_frame(5, 0, 1'b0, -1, "R5 four byte tail");
        send_frame(2, 0, 1'b1, -1, "R12 error flag");
        drain();

        // R2: idle words outside and inside a frame
        idle_word(1'b1, 1'b1);
        idle_word(1'b1, 1'b0);
        idle(3);
        chk(exp_wr.size() == 0, "R2 idle word wrote nothing", 64'(exp_wr.size()), 64'd0);
        send_frame(6, 0, 1'b0, 3, "R2 idle inside frame");
        drain();

        // R8: spill across three elements, exact fill and one beyond
        send_frame(70, 2, 1'b0, -1, "R8 spill frame");
        send_frame(32, 0, 1'b0, -1, "R8 exact element");
        send_frame(33, 0, 1'b0, -1, "R8 one word over");
        drain();

        // R11: released elements go to the tail, then get reused in order
        release_elem(held.pop_back());
        release_elem(held.pop_front());
        release_all();
        for (int i = 0; i < 8; i++)
            send_frame(1, 0, 1'b0, -1, "R11 reuse order");
        drain();
        release_all();

        // R9: exhaust the pool, then a whole frame is dropped
        while (efree.size() > 0)
            send_frame(1, 0, 1'b0, -1, "R9 fill pool");
        idle(2);
        send_frame(3, 0, 1'b0, -1, "R9 dropped frame");
        idle(2);
        chk(drop_count == 16'(drop_exp), "R9 drop count", 64'(drop_count), 64'(drop_exp));
        chk(exp_wr.size() == 0, "R9 dropped frame wrote nothing", 64'(exp_wr.size()), 64'd0);
        drain();

        // R10: one free element, frame needs two
        release_elem(held.pop_front());
        idle(2);
        send_frame(40, 0, 1'b0, -1, "R10 truncated frame");
        idle(2);
        chk(drop_count == 16'(drop_exp), "R10 tail drop count", 64'(drop_count), 64'(drop_exp));
        chk(drop_exp == 2, "R10 model drops", 64'(drop_exp), 64'd2);
        drain();
        release_all();

        // after a drop the pool still works
        send_frame(4, 0, 1'b0, -1, "R10 recovery frame");
        drain();
        idle(5);
        chk(exp_wr.size() == 0, "R3 all writes seen", 64'(exp_wr.size()), 64'd0);
        chk(exp_thr.size() == 0, "R6 no leftover thread", 64'(exp_thr.size()), 64'd0);
        summary_and_end();
    end

endmodule